// File: doc/BRIEF.md
# FIFO-Buffered SPI Master Controller

This block is a serial-peripheral-interface master that software drives through a small register bus. The bus has a write strobe, a read strobe, a word address and 32-bit data. Software sets a clock divider and a control word. It pushes words into an eight-entry transmit queue through a write-only port and pops received words from an eight-entry receive queue through a read-only port. The serial engine shifts each queued word out on MOSI while it shifts a word in from MISO. Word length, bit order, clock polarity and clock phase are all programmable. An internal loopback can replace MISO with the block's own MOSI.

Words go out back to back for as long as the transmit queue holds data. An optional level interrupt reports that the transmit side has drained completely: the queue is empty and the shift register is idle. Software keeps chip select on a general-purpose output elsewhere. A soft-reset bit in the control word holds the queues and the engine cleared for as long as it stays set.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, every readable register reads 0, SCLK, MOSI and the interrupt are low, and both queues are empty.
- R2: Word address 0 holds the divider in bits [15:0]. Word address 3 holds the control word in bits [12:0] and reads the overflow flag in bit 13. Word address 4 holds the interrupt enable in bit 2. Word address 1 reads as 0.
- R3: Each SCLK half period lasts exactly N clock cycles, where N is the divider value. A divider of 0 gives N = 65536.
- R4: The frame length is control bits [3:0] plus one. When control bit 4 is 1, the most significant bit goes first; when it is 0, the least significant bit goes first.
- R5: SCLK rests at control bit 6 (polarity), and MOSI is low while no frame is active. When control bit 5 is 0, the block samples MISO on the first edge of each bit and MOSI changes on the second edge. When bit 5 is 1, the block samples on the second edge.
- R6: When control bit 10 is 1, the receive input is the block's own MOSI, so the received words equal the transmitted words.
- R7: Frames start only while control bits 9 (enable) and 8 (master) are 1 and bit 7 is 0. While the transmit queue holds data, consecutive frames follow each other with no idle half period between them.
- R8: The interrupt output is high exactly when bit 2 of the interrupt enable is set, the transmit queue is empty and no frame is active.
- R9: While control bit 7 is 1, both queues, the engine and the overflow flag are held cleared, and writes to the transmit port are dropped.
- R10: The transmit queue holds 8 words when control bit 11 is 1 and 1 word when it is 0. A write to a full queue is dropped.
- R11: The receive queue holds 8 words when control bit 12 is 1 and 1 word when it is 0. A word that completes while the queue is full is discarded and sets the overflow flag. Any read of word address 2 clears the flag; a new overflow in the same cycle wins over the clear.
- R12: A read of word address 2 returns the oldest received word, right-aligned in bits [W-1:0], and pops it. A read of an empty queue returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at address 2) |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| irq | output | 1 | Transmit-drained interrupt, level |

## Verification
A wrong internal state shows up at the pins within one SCLK half period. A bad divider count moves an SCLK edge. A bad bit pointer puts the wrong level on MOSI. A stale busy flag or a wrong transmit count changes the interrupt level in the very next cycle. Errors in the receive path stay hidden until the next read of the receive port, so the bench reads every received word back and checks the empty and overflow cases explicitly. The reference model updates on every clock and compares SCLK, MOSI and the interrupt in every cycle, so a divergence is reported in the cycle where it first appears.

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int DEPTH  = 8,
  parameter int BAUD_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int DW = 1 << LEN_W;
  localparam int EW = LEN_W + 1;
  localparam int CTLW = 13;
  localparam logic [2:0] A_BAUD = 3'd0, A_TX = 3'd1, A_RX = 3'd2, A_CTRL = 3'd3, A_IEN = 3'd4;

  logic [BAUD_W-1:0] baud_q;
  logic [CTLW-1:0]   ctrl_q;
  logic              ien_q, ovf_q;

  logic [LEN_W-1:0] wm1;
  logic msb, cpha, cpol, srst, run, loop, txf, rxf;
  assign wm1  = ctrl_q[LEN_W-1:0];
  assign msb  = ctrl_q[4];
  assign cpha = ctrl_q[5];
  assign cpol = ctrl_q[6];
  assign srst = ctrl_q[7];
  assign run  = ctrl_q[8] & ctrl_q[9] & ~srst;
  assign loop = ctrl_q[10];
  assign txf  = ctrl_q[11];
  assign rxf  = ctrl_q[12];

  logic unused_bits;
  assign unused_bits = ^bus_wdata[31:DW];

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baud_q <= '0;
      ctrl_q <= '0;
      ien_q  <= 1'b0;
    end else if (bus_wr) begin
      if (bus_addr == A_BAUD) baud_q <= bus_wdata[BAUD_W-1:0];
      if (bus_addr == A_CTRL) ctrl_q <= bus_wdata[CTLW-1:0];
      if (bus_addr == A_IEN)  ien_q  <= bus_wdata[2];
    end
  end

  // transmit queue
  logic [DW-1:0] tx_mem [DEPTH];
  logic [AW-1:0] tx_rp, tx_wp;
  logic [CW-1:0] tx_cnt, tx_lim;
  logic wr_tx, tx_full, tx_push, tx_pop;
  assign tx_lim  = txf ? CW'(DEPTH) : CW'(1);
  assign tx_full = tx_cnt >= tx_lim;
  assign wr_tx   = bus_wr && bus_addr == A_TX;
  assign tx_push = wr_tx & ~tx_full & ~srst;

  always_ff @(posedge clk) if (tx_push) tx_mem[tx_wp] <= bus_wdata[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_rp <= '0; tx_wp <= '0; tx_cnt <= '0;
    end else if (srst) begin
      tx_rp <= '0; tx_wp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  // serial engine
  logic              busy, ph;
  logic [BAUD_W-1:0] hcnt;
  logic [EW-1:0]     ecnt, odiff;
  logic [DW-1:0]     sh_word, rx_acc, rx_next;
  logic [LEN_W-1:0]  oidx, opos, sidx, spos;
  logic tick, last, smp, din, start, rx_push;

  assign tick  = busy && hcnt == '0;
  assign last  = tick && ecnt >= {wm1, 1'b1};
  assign odiff = ecnt - EW'(cpha);
  assign oidx  = (ecnt == '0) ? '0 : odiff[EW-1:1];
  assign opos  = msb ? wm1 - oidx : oidx;
  assign sidx  = ecnt[EW-1:1];
  assign spos  = msb ? wm1 - sidx : sidx;
  assign spi_mosi = busy & sh_word[opos];
  assign spi_sclk = cpol ^ ph;
  assign din   = loop ? spi_mosi : spi_miso;
  assign smp   = tick && ecnt[0] == cpha;
  assign rx_next = rx_acc | ((smp & din) ? (DW'(1) << spos) : '0);
  assign start = run && tx_cnt != '0 && (!busy || last);
  assign tx_pop  = start;
  assign rx_push = last & ~srst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; ph <= 1'b0; hcnt <= '0; ecnt <= '0; sh_word <= '0; rx_acc <= '0;
    end else if (srst) begin
      busy <= 1'b0; ph <= 1'b0; hcnt <= '0; ecnt <= '0; rx_acc <= '0;
    end else if (start) begin
      busy <= 1'b1; ph <= 1'b0; hcnt <= baud_q - 1'b1; ecnt <= '0; rx_acc <= '0;
      sh_word <= tx_mem[tx_rp];
    end else if (last) begin
      busy <= 1'b0; ph <= 1'b0; ecnt <= '0; rx_acc <= '0;
    end else if (tick) begin
      ph <= ~ph; hcnt <= baud_q - 1'b1; ecnt <= ecnt + 1'b1; rx_acc <= rx_next;
    end else if (busy) begin
      hcnt <= hcnt - 1'b1;
    end
  end

  // receive queue
  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] rx_rp, rx_wp;
  logic [CW-1:0] rx_cnt, rx_lim;
  logic rx_rd, rx_full, rx_wr, rx_drop, rx_pop;
  assign rx_lim  = rxf ? CW'(DEPTH) : CW'(1);
  assign rx_full = rx_cnt >= rx_lim;
  assign rx_rd   = bus_rd && bus_addr == A_RX;
  assign rx_pop  = rx_rd && rx_cnt != '0 && !srst;
  assign rx_wr   = rx_push & ~rx_full;
  assign rx_drop = rx_push & rx_full;

  always_ff @(posedge clk) if (rx_wr) rx_mem[rx_wp] <= rx_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rp <= '0; rx_wp <= '0; rx_cnt <= '0; ovf_q <= 1'b0;
    end else if (srst) begin
      rx_rp <= '0; rx_wp <= '0; rx_cnt <= '0; ovf_q <= 1'b0;
    end else begin
      if (rx_wr)  rx_wp <= rx_wp + 1'b1;
      if (rx_pop) rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_wr) - CW'(rx_pop);
      if (rx_drop)    ovf_q <= 1'b1;
      else if (rx_rd) ovf_q <= 1'b0;
    end
  end

  assign irq = ien_q && tx_cnt == '0 && !busy;

  always_comb begin
    case (bus_addr)
      A_BAUD:  bus_rdata = 32'(baud_q);
      A_RX:    bus_rdata = (rx_cnt != '0) ? 32'(rx_mem[rx_rp]) : 32'd0;
      A_CTRL:  bus_rdata = 32'({ovf_q, ctrl_q});
      A_IEN:   bus_rdata = {29'd0, ien_q, 2'd0};
      default: bus_rdata = 32'd0;
    endcase
  end

  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= CW'(DEPTH) && rx_cnt <= CW'(DEPTH)); // R10
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> spi_sclk == cpol && !spi_mosi); // R5
  AST_SRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) srst |=> tx_cnt == '0 && rx_cnt == '0 && !busy && !ovf_q); // R9
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n) rx_drop |=> ovf_q); // R11
  AST_TX_DROP: assert property (@(posedge clk) disable iff (!rst_n) (wr_tx && tx_full && !tx_pop && !srst) |=> tx_cnt == $past(tx_cnt)); // R10
  AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (busy && hcnt != '0 && !srst && !(bus_wr && bus_addr == A_CTRL)) |=> $stable(spi_sclk)); // R3
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n) irq |-> !spi_mosi && spi_sclk == cpol); // R8
endmodule

// File: tb/spi_fifo_master_bench.sv
module spi_fifo_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MSB = 1 << 4, PHA = 1 << 5, POL = 1 << 6, SRST = 1 << 7;
  localparam int MST = 1 << 8, EN = 1 << 9, LOOP = 1 << 10, TXF = 1 << 11, RXF = 1 << 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, spi_miso = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic spi_sclk, spi_mosi, irq;
  logic [15:0] lfsr = 16'hACE1;

  int checks = 0, fails = 0;
  bit done = 0;

  spi_fifo_master u_spi_fifo_master (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    spi_miso <= lfsr[15];
  end

  // behavioural reference model
  int m_ctrl = 0, m_baud = 0, m_hc = 0, m_edges = 0, m_word = 0, m_rx = 0;
  bit m_ien = 0, m_ovf = 0, m_busy = 0, m_ph = 0;
  int txq[$], rxq[$];

  function automatic int bits_in_frame();
    return (m_ctrl & 15) + 1;
  endfunction

  function automatic bit model_mosi();
    int idx, pos, cph;
    if (!m_busy) return 1'b0;
    cph = (m_ctrl >> 5) & 1;
    idx = (m_edges == 0) ? 0 : (m_edges - cph) / 2;
    pos = ((m_ctrl >> 4) & 1) ? bits_in_frame() - 1 - idx : idx;
    return bit'((m_word >> pos) & 1);
  endfunction

  function automatic int model_rdata(input int a);
    case (a)
      0: return m_baud;
      2: return (rxq.size() > 0) ? rxq[0] : 0;
      3: return m_ctrl | (int'(m_ovf) << 13);
      4: return int'(m_ien) << 2;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int w, cph, e, idx, pos, rxw, tn, rn, lim_t, lim_r;
    bit run, din, pop_t, push_r;
    if (!rst_n) begin
      m_ctrl = 0; m_baud = 0; m_ien = 0; m_ovf = 0; m_busy = 0; m_ph = 0;
      m_hc = 0; m_edges = 0; m_rx = 0; txq.delete(); rxq.delete();
    end else begin
      w = bits_in_frame(); cph = (m_ctrl >> 5) & 1;
      run = ((m_ctrl >> 8) & 3) == 3 && !((m_ctrl >> 7) & 1);
      tn = txq.size(); rn = rxq.size();
      lim_t = ((m_ctrl >> 11) & 1) ? 8 : 1;
      lim_r = ((m_ctrl >> 12) & 1) ? 8 : 1;
      din = ((m_ctrl >> 10) & 1) ? model_mosi() : spi_miso;
      pop_t = 0; push_r = 0; rxw = 0;
      if ((m_ctrl >> 7) & 1) begin
        txq.delete(); rxq.delete(); m_busy = 0; m_ph = 0; m_edges = 0; m_ovf = 0; m_rx = 0;
      end else begin
        if (m_busy && m_hc == 0) begin
          e = m_edges; rxw = m_rx;
          if ((e % 2) == cph) begin
            idx = e / 2;
            pos = ((m_ctrl >> 4) & 1) ? w - 1 - idx : idx;
            if (din) rxw = rxw | (1 << pos);
          end
          m_rx = rxw; m_ph = !m_ph; m_edges = e + 1;
          m_hc = (m_baud == 0) ? 65535 : m_baud - 1;
          if (e >= 2 * w - 1) begin
            push_r = 1; m_busy = 0; m_ph = 0; m_edges = 0; m_rx = 0;
          end
        end else if (m_busy) begin
          m_hc = m_hc - 1;
        end
        if (!m_busy && run && tn > 0) begin
          pop_t = 1; m_busy = 1; m_ph = 0; m_edges = 0; m_rx = 0; m_word = txq[0];
          m_hc = (m_baud == 0) ? 65535 : m_baud - 1;
        end
        if (bus_rd && bus_addr == 3'd2) begin
          m_ovf = 0;
          if (rn > 0) void'(rxq.pop_front());
        end
        if (push_r) begin
          if (rn >= lim_r) m_ovf = 1;
          else rxq.push_back(rxw);
        end
        if (pop_t) void'(txq.pop_front());
        if (bus_wr && bus_addr == 3'd1 && tn < lim_t) txq.push_back(int'(bus_wdata[15:0]));
      end
      if (bus_wr) begin
        if (bus_addr == 3'd0) m_baud = int'(bus_wdata[15:0]);
        if (bus_addr == 3'd3) m_ctrl = int'(bus_wdata[12:0]);
        if (bus_addr == 3'd4) m_ien = bus_wdata[2];
      end
    end
  end

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle pin comparison
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      check(int'({spi_sclk, spi_mosi, irq}),
            int'({bit'(((m_ctrl >> 6) & 1) ^ m_ph), model_mosi(), bit'(m_ien && txq.size() == 0 && !m_busy)}),
            "R3/R4/R5/R7/R8 pins {sclk,mosi,irq}");
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a[2:0]; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input int a, input string tag);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a[2:0]; #1;
    check(int'(bus_rdata), model_rdata(a), tag);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic rd_lit(input int a, input int exp, input string tag);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a[2:0]; #1;
    check(int'(bus_rdata), exp, tag);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!m_busy && txq.size() == 0) break;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(int'({spi_sclk, spi_mosi, irq}), 0, "R1 pins after reset");
    rd_lit(0, 0, "R1 divider"); rd_lit(3, 0, "R1 control"); rd_lit(4, 0, "R1 enable"); rd_lit(2, 0, "R1 rx empty");

    wr(0, 7); wr(4, 32'hFFFF_FFFF); wr(3, 7 | MSB | TXF | RXF);
    rd_lit(0, 7, "R2 divider"); rd_lit(4, 4, "R2 enable bit2"); rd_lit(3, 7 | MSB | TXF | RXF, "R2 control");
    rd_lit(1, 0, "R2 tx port reads 0");
    check(int'(irq), 1, "R8 irq with empty queue");

    wr(1, 'hA5); repeat (40) @(negedge clk);
    check(int'({spi_sclk, irq}), 0, "R7 no frame while disabled");

    wr(3, 7 | MSB | MST | EN | LOOP | TXF | RXF);
    wr(1, 'h3C); wr(1, 'h81); wait_idle();
    rd_lit(2, 'hA5, "R6 loopback word 0"); rd_lit(2, 'h3C, "R6 loopback word 1");
    rd_lit(2, 'h81, "R6 loopback word 2"); rd_lit(2, 0, "R12 empty read");

    wr(3, 11 | PHA | POL | MST | EN | TXF | RXF);
    for (int i = 0; i < 5; i++) wr(1, 'h9A7 + i * 'h311);
    wait_idle();
    for (int i = 0; i < 5; i++) rd_chk(2, "R12 R4 12-bit lsb-first miso words");

    wr(3, 1 | MSB | PHA | MST | EN | LOOP | TXF | RXF);
    wr(1, 2); wr(1, 1); wait_idle();
    rd_lit(2, 2, "R4 two-bit frame"); rd_lit(2, 1, "R4 two-bit frame");
    wr(0, 9); wr(3, 15 | PHA | MST | EN | LOOP | TXF | RXF);
    wr(1, 'hBEEF); wait_idle();
    rd_lit(2, 'hBEEF, "R4 sixteen-bit lsb-first loopback");

    wr(3, 7 | MST | TXF | RXF);
    for (int i = 0; i < 10; i++) wr(1, 'h10 + i);
    wr(3, 7 | MST | EN | LOOP | TXF | RXF); wait_idle();
    for (int i = 0; i < 8; i++) rd_lit(2, 'h10 + i, "R10 eight kept");
    rd_lit(2, 0, "R10 extra pushes dropped");

    for (int i = 0; i < 8; i++) wr(1, 'h40 + i);
    wait_idle();
    wr(1, 'h77); wr(1, 'h78); wait_idle();
    rd_lit(3, (7 | MST | EN | LOOP | TXF | RXF) | (1 << 13), "R11 overflow flag set");
    rd_lit(2, 'h40, "R11 oldest kept");
    rd_lit(3, 7 | MST | EN | LOOP | TXF | RXF, "R11 flag cleared by read");
    for (int i = 1; i < 8; i++) rd_chk(2, "R11 drain");
    rd_lit(2, 0, "R11 overflowed words lost");

    wr(3, 7 | MST | LOOP);
    wr(1, 'h11); wr(1, 'h22); wr(1, 'h33);
    wr(3, 7 | MST | EN | LOOP); wait_idle();
    wr(1, 'h44); wait_idle();
    rd_lit(3, (7 | MST | EN | LOOP) | (1 << 13), "R11 single-entry overflow");
    rd_lit(2, 'h11, "R10 single-entry queue");
    rd_lit(2, 0, "R10 single-entry empty");

    wr(3, 7 | MSB | MST | EN | LOOP | TXF | RXF);
    for (int i = 0; i < 4; i++) wr(1, 'hC0 + i);
    repeat (30) @(negedge clk);
    wr(3, 7 | MSB | MST | EN | LOOP | TXF | RXF | SRST);
    wr(1, 'h55); repeat (3) @(negedge clk);
    wr(3, 7 | MSB | MST | EN | LOOP | TXF | RXF);
    repeat (3) @(negedge clk);
    rd_lit(2, 0, "R9 rx cleared by soft reset");
    check(int'({spi_sclk, irq}), 1, "R9 engine idle, tx empty");

    wr(0, 0); wr(3, 1 | MST | EN | TXF | RXF); wr(1, 3);
    repeat (100) @(negedge clk);
    check(int'(spi_sclk), 0, "R3 no edge early in 65536-cycle half period");
    repeat (65500) @(negedge clk);
    check(int'(spi_sclk), 1, "R3 first edge after 65536 cycles");
    wr(3, SRST); wr(3, 0);
    repeat (4) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule